// File: doc/BRIEF.md
# Peripheral Clock Gate Controller

This block decides whether one peripheral clock gate is open. A 32-bit control word chooses who owns the gate. Software can own it and open or close it with an enable bit. Otherwise a hardware gating request input owns it. The block drives the gate enable output, and it reports the gate's actual state through a read-only status bit. That bit lags the gate through a synchroniser, so software polls it until it shows the state it asked for.

Closing the gate can be held off by a turn-off hysteresis window. The window has a short length and a long length, both set by parameters. If the request returns while the window is counting, the close is cancelled. Opening the gate is never held off. A build-time no-disable option keeps a software-owned gate open even when software writes 0 to the enable bit.

Top module: `clk_gate_ctrl`

## Requirements
- R1: After reset the gate is closed (`gate_en` = 0), all control fields are 0 (hardware ownership, hysteresis off), and `reg_rdata` reads 0.
- R2: With the owner bit (bit 1) at 1, `gate_en` follows the enable bit (bit 0) from the second rising edge, counting the edge that samples `reg_wr`. `hw_req` then has no effect.
- R3: With the owner bit at 0, `gate_en` follows `hw_req` from the first rising edge that samples it. The enable bit has no effect.
- R4: With parameter NO_DISABLE = 1 and the owner bit at 1, the gate stays open even when bit 0 is written as 0.
- R5: The status bit (bit 4 of `reg_rdata`) equals `gate_en` delayed by 2 + STATUS_LAT clock cycles.
- R6: With hysteresis off (bit 2 = 0), the gate closes on the first rising edge that sees the request low.
- R7: With hysteresis on and the level bit (bit 3) at 0, the gate closes SHORT_DLY cycles later than it would with hysteresis off.
- R8: With hysteresis on and the level bit at 1, the gate closes LONG_DLY cycles later than it would with hysteresis off.
- R9: If the request returns before the hysteresis window ends, the gate stays open without a gap. A later close again takes the full window.
- R10: Opening is never delayed. The gate opens on the first rising edge that sees the request, whatever the hysteresis setting.
- R11: Writes to bit 4 and to bits 31:5 are ignored. Those bits read as 0, except bit 4, which reads as status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word readback, with status in bit 4 |
| hw_req | input | 1 | Hardware gating request |
| gate_en | output | 1 | Gate enable to the clock gate cell |

## Verification
The hardware request is toggled in a fixed pattern while the enable bit is set. This shows that the owner bit, not the enable bit, decides the gate. The close latency is measured in all three hysteresis modes (off, short, long), which separates the two window lengths from each other and from the direct path. The request is also returned at every offset inside the long window, which shows that a cancel at the last cycle still holds the gate open. A second instance built with the no-disable option receives the same writes, so that its behaviour can be compared with the plain gate.

// File: rtl/cg_pkg.sv
package cg_pkg;
    localparam int BIT_SW_EN     = 0;
    localparam int BIT_OWNER_SW  = 1;
    localparam int BIT_HYST_ON   = 2;
    localparam int BIT_HYST_LONG = 3;
    localparam int BIT_STATUS    = 4;

    typedef struct packed {
        logic hyst_long;
        logic hyst_on;
        logic owner_sw;
        logic sw_en;
    } cg_cfg_t;
endpackage

// File: rtl/cg_hyst_timer.sv
module cg_hyst_timer #(
    parameter int SHORT_DLY = 16,
    parameter int LONG_DLY  = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic use_long,
    output logic expired
);
    localparam int CNT_W = $clog2(LONG_DLY + 1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!arm) begin
            tmr_d.run = 1'b0;
            tmr_d.cnt = '0;
        end else if (!tmr_q.run) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = use_long ? CNT_W'(LONG_DLY - 1) : CNT_W'(SHORT_DLY - 1);
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expired = arm && tmr_q.run && (tmr_q.cnt == '0);

    // R8
    hyst_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt < CNT_W'(LONG_DLY));

    // R9
    hyst_disarm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> !tmr_q.run);
endmodule

// File: rtl/cg_status_pipe.sv
module cg_status_pipe #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [DEPTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[DEPTH-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[DEPTH-1];

    // R5
    status_first_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d |=> pipe_q[0]);
endmodule

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl #(
    parameter int NO_DISABLE = 0,
    parameter int SHORT_DLY  = 16,
    parameter int LONG_DLY   = 256,
    parameter int STATUS_LAT = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        hw_req,
    output logic        gate_en
);
    import cg_pkg::*;

    localparam int PIPE_DEPTH = 2 + STATUS_LAT;
    localparam bit KEEP_ON    = (NO_DISABLE != 0);

    typedef struct packed {
        cg_cfg_t cfg;
        logic    gate;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic req_c;
    logic arm_c;
    logic expired;
    logic status;

    cg_hyst_timer #(
        .SHORT_DLY(SHORT_DLY),
        .LONG_DLY (LONG_DLY)
    ) hyst_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm_c),
        .use_long(ctl_q.cfg.hyst_long),
        .expired (expired)
    );

    cg_status_pipe #(
        .DEPTH(PIPE_DEPTH)
    ) stat_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (ctl_q.gate),
        .q    (status)
    );

    always_comb begin
        req_c = ctl_q.cfg.owner_sw ? (ctl_q.cfg.sw_en | KEEP_ON) : hw_req;
        arm_c = ctl_q.gate && !req_c && ctl_q.cfg.hyst_on;
    end

    always_comb begin
        ctl_d = ctl_q;
        if (reg_wr) begin
            ctl_d.cfg.sw_en     = reg_wdata[BIT_SW_EN];
            ctl_d.cfg.owner_sw  = reg_wdata[BIT_OWNER_SW];
            ctl_d.cfg.hyst_on   = reg_wdata[BIT_HYST_ON];
            ctl_d.cfg.hyst_long = reg_wdata[BIT_HYST_LONG];
        end
        if (req_c)                  ctl_d.gate = 1'b1;
        else if (!ctl_q.cfg.hyst_on) ctl_d.gate = 1'b0;
        else                        ctl_d.gate = ctl_q.gate && !expired;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        reg_rdata                = '0;
        reg_rdata[BIT_SW_EN]     = ctl_q.cfg.sw_en;
        reg_rdata[BIT_OWNER_SW]  = ctl_q.cfg.owner_sw;
        reg_rdata[BIT_HYST_ON]   = ctl_q.cfg.hyst_on;
        reg_rdata[BIT_HYST_LONG] = ctl_q.cfg.hyst_long;
        reg_rdata[BIT_STATUS]    = status;
    end

    assign gate_en = ctl_q.gate;

    // R10
    turn_on_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.cfg.owner_sw && hw_req) |=> gate_en);

    // R2
    sw_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.cfg.owner_sw && ctl_q.cfg.sw_en) |=> gate_en);

    // R6
    no_hyst_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.cfg.hyst_on && !ctl_q.cfg.owner_sw && !hw_req) |=> !gate_en);

    // R4
    no_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (KEEP_ON && ctl_q.cfg.owner_sw) |=> gate_en);

    // R9
    cancel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && !ctl_q.cfg.owner_sw && hw_req) |=> gate_en);
endmodule

// File: tb/clk_gate_ctrl_tb_top.sv
module clk_gate_ctrl_tb_top;
    localparam int SHORT = 4;
    localparam int LONG  = 12;
    localparam int LAT   = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        hw_req = 1'b0;
    logic [31:0] rdata, rdata_nd;
    logic        gate_en, gate_en_nd;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    clk_gate_ctrl #(.NO_DISABLE(0), .SHORT_DLY(SHORT), .LONG_DLY(LONG), .STATUS_LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata), .hw_req(hw_req), .gate_en(gate_en));

    clk_gate_ctrl #(.NO_DISABLE(1), .SHORT_DLY(SHORT), .LONG_DLY(LONG), .STATUS_LAT(LAT)) dut_nd_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(rdata_nd), .hw_req(hw_req), .gate_en(gate_en_nd));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic measure_fall(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (gate_en && n < 100);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        bit stayed;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(gate_en == 1'b0, "R1 gate", gate_en, 0);
        chk(rdata == 32'h0, "R1 rdata", rdata, 0);

        // R3 hardware ownership, enable bit set but ignored
        wr(32'h1);
        @(negedge clk);
        chk(gate_en == 1'b0, "R3 enable bit ignored", gate_en, 0);
        begin
            bit pat [8] = '{1, 1, 0, 1, 0, 0, 1, 0};
            foreach (pat[i]) begin
                hw_req = pat[i];
                @(negedge clk);
                chk(gate_en == pat[i], "R3 follow hw_req", gate_en, pat[i]);
            end
        end

        // R5 status lag
        wr(32'h0);
        repeat (6) @(negedge clk);
        hw_req = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rdata[4] && n < 50);
        chk(n == 1 + 2 + LAT, "R5 status rise lag", n, 1 + 2 + LAT);
        hw_req = 1'b0;
        @(negedge clk);
        chk(gate_en == 1'b0 && rdata[4] == 1'b1, "R5 status still high", rdata[4], 1);
        n = 1;
        while (rdata[4] && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk(n == 1 + 2 + LAT, "R5 status fall lag", n, 1 + 2 + LAT);

        // R6/R7/R8/R10 hysteresis mode sweep
        for (int m = 0; m < 3; m++) begin
            int expn;
            hw_req = 1'b0;
            wr((m > 0 ? 32'h4 : 32'h0) | (m == 2 ? 32'h8 : 32'h0));
            repeat (20) @(negedge clk);
            chk(gate_en == 1'b0, "R10 idle closed", gate_en, 0);
            hw_req = 1'b1;
            @(negedge clk);
            chk(gate_en == 1'b1, "R10 open without delay", gate_en, 1);
            repeat (3) @(negedge clk);
            hw_req = 1'b0;
            measure_fall(n);
            expn = (m == 0) ? 1 : (m == 1 ? 1 + SHORT : 1 + LONG);
            if (m == 0)      chk(n == expn, "R6 close latency", n, expn);
            else if (m == 1) chk(n == expn, "R7 short close latency", n, expn);
            else             chk(n == expn, "R8 long close latency", n, expn);
        end

        // R9 cancel at every offset of the long window
        for (int k = 1; k <= LONG; k++) begin
            hw_req = 1'b1;
            repeat (3) @(negedge clk);
            hw_req = 1'b0;
            stayed = 1'b1;
            repeat (k) begin
                @(negedge clk);
                if (!gate_en) stayed = 1'b0;
            end
            hw_req = 1'b1;
            repeat (LONG + 4) begin
                @(negedge clk);
                if (!gate_en) stayed = 1'b0;
            end
            chk(stayed, "R9 cancel keeps gate open", stayed, 1);
            hw_req = 1'b0;
            measure_fall(n);
            chk(n == 1 + LONG, "R9 full window after cancel", n, 1 + LONG);
        end

        // R2 software ownership
        hw_req = 1'b0;
        wr(32'h3);
        chk(gate_en == 1'b0, "R2 not yet open", gate_en, 0);
        @(negedge clk);
        chk(gate_en == 1'b1, "R2 open after write", gate_en, 1);
        wr(32'h2);
        @(negedge clk);
        chk(gate_en == 1'b0, "R2 closed after write", gate_en, 0);
        hw_req = 1'b1;
        repeat (3) @(negedge clk);
        chk(gate_en == 1'b0, "R2 hw_req ignored", gate_en, 0);
        // R4 no-disable instance under the same writes
        chk(gate_en_nd == 1'b1, "R4 stays open with enable 0", gate_en_nd, 1);
        wr(32'h3);
        @(negedge clk);
        chk(gate_en_nd == 1'b1, "R4 open with enable 1", gate_en_nd, 1);
        wr(32'h2);
        repeat (4) @(negedge clk);
        chk(gate_en_nd == 1'b1, "R4 disable write ignored", gate_en_nd, 1);
        hw_req = 1'b0;

        // R11 ignored bits
        wr(32'hFFFF_FFFF);
        repeat (10) @(negedge clk);
        chk(rdata == 32'h1F, "R11 readback all-ones write", rdata, 32'h1F);
        wr(32'h10);
        repeat (10) @(negedge clk);
        chk(rdata == 32'h0, "R11 status not writable", rdata, 0);
        chk(gate_en == 1'b0, "R11 gate closed", gate_en, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule